// File: doc/BRIEF.md
# Quadrature Position Decoder with Split Angle/Turn Count

This block turns the two phase signals of an incremental encoder into a 16-bit position count. The count has two fields. The low field counts angle within one turn. The high field counts whole turns. A 3-bit length setting picks the boundary between them at run time. When the angle field passes its top value going up, it returns to zero and the turn field goes up by one. When it passes zero going down, it reloads its top value and the turn field goes down by one. The top value is normally all ones in the angle field. When the period option is on, a programmed period sets it instead.

Each phase can come from a device pin or from an internal event line. A pin source can have its level inverted. The two phases can also be swapped. Both conditioned phases pass through a two-flop synchronizer before edge detection. In four-edge mode every edge of either phase moves the count by one. In two-edge mode only edges of phase A move it. The block also gives the direction of the last counted step. A sticky error flag is set when both phases change in the same cycle.

Top module: `qdec_angle_rev`

## Requirements
- R1: After reset the count is 0x0000, the direction output is 0 and the error output is 0.
- R2: With `x2_mode` = 0, every single edge of either phase changes the count by one. The phase pair {A,B} moving through 00, 10, 11, 01 (A leading) counts up, and the reverse order counts down. With no edge the count holds.
- R3: With `x2_mode` = 1, only edges of phase A change the count. An edge of phase B alone leaves the count unchanged.
- R4: The angle field is `ang_len`+9 bits wide, and the bits above it form the turn field. An up step from the angle field's top value clears the angle field and adds one to the turn field.
- R5: A down step with the angle field at zero loads the angle field with its top value and subtracts one from the turn field.
- R6: With `ang_len` = 7 the whole 16-bit count is angle. An up step from 0xFFFF gives 0x0000, and a down step from 0x0000 gives 0xFFFF.
- R7: With `period_en` = 1, the angle field's top value is `period` (masked to the angle field width), and the wrap rules of R4 and R5 use that value.
- R8: Bit i of `use_pin` selects the pin (1) or the event line (0) as the source of input i, where input 0 is `pin_a`/`evt_a` and input 1 is `pin_b`/`evt_b`. The input that is not selected has no effect on the count.
- R9: Bit i of `pin_inv` inverts the level of input i only when bit i of `use_pin` is 1. When the event line is selected, the bit has no effect.
- R10: With `swap` = 1, input 1 drives phase A and input 0 drives phase B.
- R11: If both phases change in the same cycle, the count does not change, and `err` becomes 1 and stays 1 until reset.
- R12: `dir` is 1 when the last counted step was up and 0 when it was down. It changes only on a counted step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Pin source for input 0 |
| pin_b | input | 1 | Pin source for input 1 |
| evt_a | input | 1 | Event-line source for input 0 |
| evt_b | input | 1 | Event-line source for input 1 |
| use_pin | input | 2 | Per-input source select: 1 = pin, 0 = event line |
| pin_inv | input | 2 | Per-input level inversion, used only for pin sources |
| swap | input | 1 | Exchange the two inputs between phase A and phase B |
| x2_mode | input | 1 | 1 = count only phase A edges, 0 = count all edges |
| ang_len | input | 3 | Angle field width minus 9 |
| period_en | input | 1 | Use `period` as the angle field's top value |
| period | input | 16 | Angle field top value when enabled |
| count | output | 16 | Position: turn field above angle field |
| dir | output | 1 | Direction of the last counted step, 1 = up |
| err | output | 1 | Sticky flag for a simultaneous change of both phases |

## Verification
The encoder sequence is applied forward and backward in four-edge mode, so that a wrong sign or a wrong edge rule shows up as a mismatch in the count and in the direction. In two-edge mode, full cycles are followed by a lone phase-B edge, which shows whether B edges are really ignored. Long runs up to the angle boundary, at the narrowest, the full-width and the period-limited settings, tell a carry into the turn field apart from a plain increment, and a reload with a borrow apart from a plain decrement. Source, inversion and swap settings are each tried with stimulus that would count differently, or not at all, if the setting were applied to the wrong input. A simultaneous change of both phases checks that the count is frozen and that the error flag stays set.

// File: rtl/qdec_pkg.sv
`timescale 1ns/1ps
package qdec_pkg;
   localparam int unsigned NUM_PH = 2;
   localparam int unsigned PH_A   = 0;
   localparam int unsigned PH_B   = 1;

   typedef struct packed {
      logic valid;
      logic up;
      logic clash;
   } qstep_t;
endpackage

// File: rtl/qdec_in_cond.sv
`timescale 1ns/1ps
module qdec_in_cond
   import qdec_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_PH-1:0] pin,
   input  logic [NUM_PH-1:0] evt,
   input  logic [NUM_PH-1:0] use_pin,
   input  logic [NUM_PH-1:0] pin_inv,
   input  logic              swap,
   output logic [NUM_PH-1:0] ph
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("qdec_in_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PH-1:0] src;
   logic [NUM_PH-1:0] ordered;

   for (genvar i = 0; i < NUM_PH; i++) begin : g_src
      assign src[i] = use_pin[i] ? (pin[i] ^ pin_inv[i]) : evt[i];
   end

   assign ordered[PH_A] = swap ? src[PH_B] : src[PH_A];
   assign ordered[PH_B] = swap ? src[PH_A] : src[PH_B];

   for (genvar i = 0; i < NUM_PH; i++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], ordered[i]};
      end
      assign ph[i] = chain[SYNC_STAGES-1];
   end
endmodule

// File: rtl/qdec_step_dec.sv
`timescale 1ns/1ps
module qdec_step_dec
   import qdec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_PH-1:0] ph,
   input  logic              x2_mode,
   output qstep_t            stp
);
   logic [NUM_PH-1:0] prev;
   logic [NUM_PH-1:0] chg;
   logic              lead_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= ph;
   end

   assign chg     = ph ^ prev;
   assign lead_up = ph[PH_A] ^ ph[PH_B];

   always_comb begin
      stp.clash = &chg;
      if (x2_mode) stp.valid = chg[PH_A] & ~chg[PH_B];
      else         stp.valid = ^chg;
      stp.up = chg[PH_A] ? lead_up : ~lead_up;
   end

   // R3: in two-edge mode a lone phase-B change never counts
   p_x2_ignores_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (x2_mode && ph[PH_B] != prev[PH_B] && ph[PH_A] == prev[PH_A]) |-> !stp.valid);
endmodule

// File: rtl/qdec_pos_cnt.sv
`timescale 1ns/1ps
module qdec_pos_cnt #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ANG_MIN = 9,
   parameter int unsigned LEN_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_valid,
   input  logic             step_up,
   input  logic [LEN_W-1:0] ang_len,
   input  logic             period_en,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned EXT_W = CNT_W + 1;
   localparam int unsigned SH_W  = $clog2(CNT_W + 1);

   generate
      if (ANG_MIN + (2 ** LEN_W) - 1 > CNT_W) begin : g_bad_len
         $error("qdec_pos_cnt: widest angle field exceeds CNT_W");
      end
   endgenerate

   logic [SH_W-1:0]  ang_w;
   logic [EXT_W-1:0] unit_ext;
   logic [CNT_W-1:0] amask;
   logic [CNT_W-1:0] rev_unit;
   logic [CNT_W-1:0] amax;
   logic [CNT_W-1:0] ang;
   logic [CNT_W-1:0] revp;
   logic [CNT_W-1:0] cnt_nxt;

   assign ang_w    = SH_W'(ANG_MIN) + SH_W'(ang_len);
   assign unit_ext = EXT_W'(1) << ang_w;
   assign amask    = CNT_W'(unit_ext - EXT_W'(1));
   assign rev_unit = CNT_W'(unit_ext);
   assign amax     = period_en ? (period & amask) : amask;
   assign ang      = count & amask;
   assign revp     = count & ~amask;

   always_comb begin
      cnt_nxt = count;
      if (step_valid) begin
         if (step_up) begin
            if (ang == amax) cnt_nxt = revp + rev_unit;
            else             cnt_nxt = count + CNT_W'(1);
         end else begin
            if (ang == '0)   cnt_nxt = (revp - rev_unit) | amax;
            else             cnt_nxt = count - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= cnt_nxt;
   end

   // R2: without a counted step the position holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid |=> $stable(count));
   // R4: an up step at the angle top leaves the angle field cleared
   p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && step_up && ang == amax) |=> ((count & $past(amask)) == '0));
   // R5: a down step at angle zero leaves the angle field at its top value
   p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !step_up && ang == '0) |=> ((count & $past(amask)) == $past(amax)));
endmodule

// File: rtl/qdec_angle_rev.sv
`timescale 1ns/1ps
module qdec_angle_rev
   import qdec_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ANG_MIN     = 9,
   parameter int unsigned LEN_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_a,
   input  logic             pin_b,
   input  logic             evt_a,
   input  logic             evt_b,
   input  logic [1:0]       use_pin,
   input  logic [1:0]       pin_inv,
   input  logic             swap,
   input  logic             x2_mode,
   input  logic [LEN_W-1:0] ang_len,
   input  logic             period_en,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             dir,
   output logic             err
);
   logic [NUM_PH-1:0] ph;
   qstep_t            stp;

   qdec_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     ({pin_b, pin_a}),
      .evt     ({evt_b, evt_a}),
      .use_pin (use_pin),
      .pin_inv (pin_inv),
      .swap    (swap),
      .ph      (ph)
   );

   qdec_step_dec u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .ph      (ph),
      .x2_mode (x2_mode),
      .stp     (stp)
   );

   qdec_pos_cnt #(.CNT_W(CNT_W), .ANG_MIN(ANG_MIN), .LEN_W(LEN_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_valid (stp.valid),
      .step_up    (stp.up),
      .ang_len    (ang_len),
      .period_en  (period_en),
      .period     (period),
      .count      (count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= 1'b0;
         err <= 1'b0;
      end else begin
         if (stp.valid) dir <= stp.up;
         if (stp.clash) err <= 1'b1;
      end
   end

   // R11: the error flag never clears outside reset
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R11: the cycle that raises the flag does not move the count
   p_err_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (count == $past(count)));
   // R12: direction moves only on a counted step
   p_dir_on_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (dir != $past(dir)) |-> $past(stp.valid));
endmodule

// File: tb/qdec_angle_rev_test.sv
`timescale 1ns/1ps
module qdec_angle_rev_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_a = 1'b0, pin_b = 1'b0, evt_a = 1'b0, evt_b = 1'b0;
   logic [1:0]  use_pin = 2'b11;
   logic [1:0]  pin_inv = 2'b00;
   logic        swap = 1'b0;
   logic        x2_mode = 1'b0;
   logic [2:0]  ang_len = 3'd0;
   logic        period_en = 1'b0;
   logic [15:0] period = 16'h0000;
   logic [15:0] count;
   logic        dir, err;

   int n_chk = 0;
   int n_bad = 0;
   logic [1:0] g = 2'd0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   qdec_angle_rev uut (
      .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
      .evt_a(evt_a), .evt_b(evt_b), .use_pin(use_pin), .pin_inv(pin_inv),
      .swap(swap), .x2_mode(x2_mode), .ang_len(ang_len),
      .period_en(period_en), .period(period),
      .count(count), .dir(dir), .err(err)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset(input logic pa, input logic pb, input logic ea, input logic eb);
      @(negedge clk);
      rst_n = 1'b0;
      pin_a = pa; pin_b = pb; evt_a = ea; evt_b = eb;
      g = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cfg_default();
      use_pin = 2'b11; pin_inv = 2'b00; swap = 1'b0; x2_mode = 1'b0;
      ang_len = 3'd0; period_en = 1'b0; period = 16'h0000;
   endtask

   // one encoder step on the pins; {A,B} sequence 00,10,11,01 is up
   task automatic gstep(input bit up);
      g = up ? g + 2'd1 : g - 2'd1;
      pin_a = g[0] ^ g[1];
      pin_b = g[1];
      settle();
   endtask

   task automatic t_reset();
      cfg_default();
      do_reset(0, 0, 0, 0);
      chk("R1 count", count, 16'h0000);
      chk("R1 dir", {15'd0, dir}, 16'h0000);
      chk("R1 err", {15'd0, err}, 16'h0000);
   endtask

   task automatic t_x4();
      cfg_default();
      do_reset(0, 0, 0, 0);
      for (int i = 0; i < 5; i++) gstep(1);
      chk("R2 five up", count, 16'd5);
      chk("R12 dir up", {15'd0, dir}, 16'd1);
      gstep(0); gstep(0);
      chk("R2 two down", count, 16'd3);
      chk("R12 dir down", {15'd0, dir}, 16'd0);
   endtask

   task automatic t_x2();
      cfg_default();
      x2_mode = 1'b1;
      do_reset(0, 0, 0, 0);
      for (int i = 0; i < 4; i++) gstep(1);
      chk("R3 full cycle", count, 16'd2);
      pin_b = 1'b1;
      settle();
      chk("R3 lone B edge", count, 16'd2);
   endtask

   task automatic t_wrap();
      cfg_default();
      do_reset(0, 0, 0, 0);
      for (int i = 0; i < 511; i++) gstep(1);
      chk("R4 angle top", count, 16'h01FF);
      gstep(1);
      chk("R4 carry to turn", count, 16'h0200);
      gstep(0);
      chk("R5 borrow from turn", count, 16'h01FF);
      cfg_default();
      ang_len = 3'd2;
      do_reset(0, 0, 0, 0);
      gstep(0);
      chk("R5 reload 11-bit", count, 16'hFFFF);
   endtask

   task automatic t_full();
      cfg_default();
      ang_len = 3'd7;
      do_reset(0, 0, 0, 0);
      gstep(0);
      chk("R6 down from zero", count, 16'hFFFF);
      gstep(1);
      chk("R6 up from top", count, 16'h0000);
   endtask

   task automatic t_period();
      cfg_default();
      period_en = 1'b1;
      period = 16'd5;
      do_reset(0, 0, 0, 0);
      for (int i = 0; i < 5; i++) gstep(1);
      chk("R7 at period", count, 16'd5);
      gstep(1);
      chk("R7 wrap at period", count, 16'h0200);
      gstep(0);
      chk("R7 reload period", count, 16'h0005);
   endtask

   task automatic t_source();
      cfg_default();
      use_pin = 2'b00;
      pin_inv = 2'b11;
      do_reset(0, 0, 0, 0);
      pin_a = 1'b1;
      settle();
      chk("R8 unselected pin", count, 16'd0);
      evt_a = 1'b1;
      settle();
      chk("R8 event source", count, 16'd1);
      chk("R9 no inversion on event", {15'd0, dir}, 16'd1);
      cfg_default();
      pin_inv = 2'b01;
      do_reset(1, 0, 0, 0);
      pin_a = 1'b0;
      settle();
      chk("R9 inverted pin", count, 16'd1);
   endtask

   task automatic t_swap();
      cfg_default();
      swap = 1'b1;
      do_reset(0, 0, 0, 0);
      pin_b = 1'b1;
      settle();
      chk("R10 swapped lead", count, 16'd1);
      pin_a = 1'b1;
      settle();
      chk("R10 swapped second", count, 16'd2);
   endtask

   task automatic t_err();
      cfg_default();
      do_reset(0, 0, 0, 0);
      pin_a = 1'b1; pin_b = 1'b1;
      settle();
      chk("R11 count frozen", count, 16'd0);
      chk("R11 err set", {15'd0, err}, 16'd1);
      g = 2'd2;
      gstep(1);
      chk("R11 err sticky", {15'd0, err}, 16'd1);
      chk("R2 counts after clash", count, 16'd1);
   endtask

   initial begin
      t_reset();
      t_x4();
      t_x2();
      t_wrap();
      t_full();
      t_period();
      t_source();
      t_swap();
      t_err();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(10 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule